// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the execute stage of a small 8-bit RISC datapath. The surrounding core decodes an instruction and presents two operands (a register value and either a second register or an immediate), an operation code and a bit index. The result and its write-back enable come straight out of combinational logic in the same cycle. The eight status flags live in a register inside the block, and that register is updated on the clock edge that completes a valid operation.

Each operation family touches only its own group of flags. The other flags keep their values, so the core can interleave flag-neutral moves with arithmetic and then branch on the older flags. Subtract-with-carry and compare-with-carry can only keep or clear the zero flag. This lets a chain of byte-wide compares test a multi-byte value for equality. Compares produce flags but never ask for a register write.

Status layout (bit positions are part of the behaviour, since flags are addressed by index): bit 0 C (carry/borrow), bit 1 Z, bit 2 N, bit 3 V, bit 4 S, bit 5 H, bit 6 T, bit 7 I. Single-operand operations take their operand on `opnd_a`.

Top module: `alu8_core`

## Requirements
- R1: After reset the status register reads 0x00.
- R2: Add (op 0) and add-with-carry (op 1, adds the incoming C) return (a+b+cin) mod 256, set C to the carry out of bit 7, set H to the carry out of bit 3, set V on signed overflow, and set N to result bit 7 and Z when the result is zero.
- R3: Subtract (op 2), subtract-with-carry (op 3, subtracts the incoming C) and negate (op 6, computes 0 minus a) return the difference mod 256. They set C on an unsigned borrow, H on a borrow out of the low nibble, V on signed overflow, and N from the result.
- R4: For ops 3 and 5, Z becomes 1 only if the result is zero and Z was already 1. Otherwise Z becomes 0.
- R5: Compare (op 4) and compare-with-carry (op 5) update the flags exactly as subtract and subtract-with-carry do, but result_we stays 0.
- R6: AND (op 8), OR (op 9), XOR (op 10), increment (op 11) and decrement (op 12) write their result and leave C and H unchanged. V is 0 for the three logic ops. For increment, V is set when the result is 0x80; for decrement, when it is 0x7F.
- R7: One's complement (op 7) returns 0xFF minus a, sets C to 1 and V to 0, and leaves H unchanged.
- R8: Shift left (op 13) and rotate left through carry (op 15) move bit 7 into C and put 0 or the old C into bit 0; H takes operand bit 3. Shift right (op 14) puts 0 into bit 7, rotate right (op 16) puts the old C into bit 7, and arithmetic shift right (op 17) keeps bit 7; all three move bit 0 into C and leave H unchanged. For every shift, V = N xor C after the operation.
- R9: Nibble swap (op 18) and set-all (op 19, result 0xFF) write a result and change no flag.
- R10: Flag set (op 20) and flag clear (op 21) force status bit bit_idx to 1 or 0, leave the other bits as they were, and do not write a result.
- R11: Bit store (op 22) copies opnd_a[bit_idx] into T without writing a result. Bit load (op 23) returns opnd_a with bit bit_idx replaced by T and changes no flag.
- R12: Opcodes 24 to 31, and any cycle with op_valid low, write no result and leave the status register unchanged.
- R13: Every operation that updates N and V also sets S to N xor V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation code |
| opnd_a | input | 8 | Destination operand, or the single operand |
| opnd_b | input | 8 | Source register or immediate operand |
| bit_idx | input | 3 | Bit index for flag set/clear and bit store/load |
| result | output | 8 | Combinational result |
| result_we | output | 1 | Result should be written back |
| status | output | 8 | Registered status flags |

## Verification
A wrong result or write enable appears at the ports in the same cycle the operation is presented. A wrong flag appears on `status` one clock later. The bench models the status register itself and compares it after every operation. A flag that was corrupted earlier therefore shows up at once, and it also corrupts the carry or zero used by the next carry-chained operation. Flags are forced to chosen carry and zero values before each operation, so both incoming values reach every opcode. The zero-chaining rule is seen as a zero flag that stays cleared after an equal compare.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int BW  = $clog2(DW);
  localparam int FW  = 8;
  localparam int OPW = 5;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FN = 2;
  localparam int FV = 3;
  localparam int FS = 4;
  localparam int FH = 5;
  localparam int FT = 6;
  localparam int FI = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD    = 5'd0,  OP_ADC   = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP    = 5'd4,  OP_CPC   = 5'd5,  OP_NEG  = 5'd6,  OP_COM  = 5'd7,
    OP_AND    = 5'd8,  OP_OR    = 5'd9,  OP_XOR  = 5'd10, OP_INC  = 5'd11,
    OP_DEC    = 5'd12, OP_LSL   = 5'd13, OP_LSR  = 5'd14, OP_ROL  = 5'd15,
    OP_ROR    = 5'd16, OP_ASR   = 5'd17, OP_SWAP = 5'd18, OP_SETA = 5'd19,
    OP_FSET   = 5'd20, OP_FCLR  = 5'd21, OP_BST  = 5'd22, OP_BLD  = 5'd23
  } opcode_e;

  typedef struct packed {
    logic [DW-1:0] r;
    logic          c;
    logic          h;
    logic          v;
  } arith_t;

  function automatic arith_t add_fn(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                    input logic ci);
    arith_t o;
    logic [DW:0] full;
    logic [NW:0] lo;
    full = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, ci};
    lo   = {1'b0, a[NW-1:0]} + {1'b0, b[NW-1:0]} + {{NW{1'b0}}, ci};
    o.r  = full[DW-1:0];
    o.c  = full[DW];
    o.h  = lo[NW];
    o.v  = (a[DW-1] == b[DW-1]) && (full[DW-1] != a[DW-1]);
    return o;
  endfunction

  function automatic arith_t sub_fn(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                    input logic ci);
    arith_t o;
    logic [DW:0] full;
    logic [NW:0] lo;
    full = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, ci};
    lo   = {1'b0, a[NW-1:0]} - {1'b0, b[NW-1:0]} - {{NW{1'b0}}, ci};
    o.r  = full[DW-1:0];
    o.c  = full[DW];
    o.h  = lo[NW];
    o.v  = (a[DW-1] != b[DW-1]) && (full[DW-1] != a[DW-1]);
    return o;
  endfunction

  function automatic logic [DW-1:0] swap_fn(input logic [DW-1:0] a);
    return {a[NW-1:0], a[DW-1:NW]};
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          ci,
  input  logic          sub,
  output logic [DW-1:0] r,
  output logic          co,
  output logic          hc,
  output logic          ov
);
  arith_t res;

  always_comb begin
    res = sub ? sub_fn(a, b, ci) : add_fn(a, b, ci);
    r   = res.r;
    co  = res.c;
    hc  = res.h;
    ov  = res.v;
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
(
  input  opcode_e       opc,
  input  logic [DW-1:0] a,
  input  logic          ci,
  output logic [DW-1:0] r,
  output logic          co
);
  always_comb begin
    r  = a;
    co = 1'b0;
    case (opc)
      OP_LSL: begin r = {a[DW-2:0], 1'b0};    co = a[DW-1]; end
      OP_ROL: begin r = {a[DW-2:0], ci};      co = a[DW-1]; end
      OP_LSR: begin r = {1'b0, a[DW-1:1]};    co = a[0];    end
      OP_ROR: begin r = {ci, a[DW-1:1]};      co = a[0];    end
      OP_ASR: begin r = {a[DW-1], a[DW-1:1]}; co = a[0];    end
      default: begin r = a; co = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  opcode_e       opc,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] r,
  output logic          ov
);
  localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] MOST_POS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    r  = a;
    ov = 1'b0;
    case (opc)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_COM: r = ~a;
      OP_INC: begin r = a + ONE; ov = (r == MOST_NEG); end
      OP_DEC: begin r = a - ONE; ov = (r == MOST_POS); end
      default: r = a;
    endcase
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] nxt,
  output logic [FW-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= nxt;
  end

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [DW-1:0]  opnd_a,
  input  logic [DW-1:0]  opnd_b,
  input  logic [BW-1:0]  bit_idx,
  output logic [DW-1:0]  result,
  output logic           result_we,
  output logic [FW-1:0]  status
);
  opcode_e       opc;
  logic [DW-1:0] as_a, as_b, as_r;
  logic          as_ci, as_sub, as_c, as_h, as_v;
  logic [DW-1:0] sh_r, lg_r;
  logic          sh_c, lg_v;
  logic [FW-1:0] st_nxt;
  logic [DW-1:0] res_c;
  logic          we_c;
  logic          nzvs_upd;
  logic          is_chain, is_cmp, is_logic, flag_quiet;
  logic          z_raw;

  assign opc = opcode_e'(op_code);

  // operand steering for the adder/subtractor
  always_comb begin
    as_sub = (opc == OP_SUB) || (opc == OP_SBC) || (opc == OP_CMP) ||
             (opc == OP_CPC) || (opc == OP_NEG);
    as_a   = (opc == OP_NEG) ? '0 : opnd_a;
    as_b   = (opc == OP_NEG) ? opnd_a : opnd_b;
    as_ci  = ((opc == OP_ADC) || (opc == OP_SBC) || (opc == OP_CPC)) ? status[FC] : 1'b0;
  end

  assign is_chain   = (opc == OP_SBC) || (opc == OP_CPC);
  assign is_cmp     = (opc == OP_CMP) || (opc == OP_CPC);
  assign is_logic   = (opc == OP_AND) || (opc == OP_OR) || (opc == OP_XOR);
  assign flag_quiet = (opc == OP_SWAP) || (opc == OP_SETA) || (opc == OP_BLD);

  alu8_addsub u_addsub (
    .a(as_a), .b(as_b), .ci(as_ci), .sub(as_sub),
    .r(as_r), .co(as_c), .hc(as_h), .ov(as_v)
  );

  alu8_shift u_shift (
    .opc(opc), .a(opnd_a), .ci(status[FC]), .r(sh_r), .co(sh_c)
  );

  alu8_logic u_logic (
    .opc(opc), .a(opnd_a), .b(opnd_b), .r(lg_r), .ov(lg_v)
  );

  always_comb begin
    res_c    = opnd_a;
    we_c     = 1'b0;
    st_nxt   = status;
    nzvs_upd = 1'b0;
    z_raw    = 1'b0;
    case (opc)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CPC: begin
        res_c      = as_r;
        we_c       = !is_cmp;
        nzvs_upd   = 1'b1;
        z_raw      = (as_r == '0);
        st_nxt[FC] = as_c;
        st_nxt[FH] = as_h;
        st_nxt[FV] = as_v;
        st_nxt[FN] = as_r[DW-1];
        st_nxt[FZ] = is_chain ? (z_raw & status[FZ]) : z_raw;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_COM: begin
        res_c      = lg_r;
        we_c       = 1'b1;
        nzvs_upd   = 1'b1;
        st_nxt[FV] = lg_v;
        st_nxt[FN] = lg_r[DW-1];
        st_nxt[FZ] = (lg_r == '0);
        if (opc == OP_COM) st_nxt[FC] = 1'b1;
      end
      OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR: begin
        res_c      = sh_r;
        we_c       = 1'b1;
        nzvs_upd   = 1'b1;
        st_nxt[FC] = sh_c;
        st_nxt[FN] = sh_r[DW-1];
        st_nxt[FV] = sh_r[DW-1] ^ sh_c;
        st_nxt[FZ] = (sh_r == '0);
        if ((opc == OP_LSL) || (opc == OP_ROL)) st_nxt[FH] = opnd_a[NW-1];
      end
      OP_SWAP: begin res_c = swap_fn(opnd_a); we_c = 1'b1; end
      OP_SETA: begin res_c = '1;              we_c = 1'b1; end
      OP_FSET: st_nxt[bit_idx] = 1'b1;
      OP_FCLR: st_nxt[bit_idx] = 1'b0;
      OP_BST:  st_nxt[FT] = opnd_a[bit_idx];
      OP_BLD: begin
        res_c          = opnd_a;
        res_c[bit_idx] = status[FT];
        we_c           = 1'b1;
      end
      default: begin res_c = opnd_a; we_c = 1'b0; end
    endcase
    if (nzvs_upd) st_nxt[FS] = st_nxt[FN] ^ st_nxt[FV];
  end

  assign result    = res_c;
  assign result_we = we_c & op_valid;

  alu8_status u_status (
    .clk(clk), .rst_n(rst_n), .load(op_valid), .nxt(st_nxt), .q(status)
  );

  // R13
  s_matches_nv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && nzvs_upd |=> status[FS] == (status[FN] ^ status[FV]));

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_cmp |-> !result_we);

  // R9
  quiet_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && flag_quiet |=> $stable(status));

  // R4
  z_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_chain && !status[FZ] |=> !status[FZ]);

  // R6
  logic_keep_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_logic |=> (status[FC] == $past(status[FC])) &&
                             (status[FH] == $past(status[FH])) && !status[FV]);
endmodule

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic [2:0] bit_idx = '0;
  logic [7:0] result;
  logic       result_we;
  logic [7:0] status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_st = '0;

  always #4 clk = ~clk;

  alu8_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_idx(bit_idx),
    .result(result), .result_we(result_we), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string req_tag(input int op);
    if (op <= 1) return "R2";
    if (op == 2 || op == 3 || op == 6) return "R3";
    if (op == 4 || op == 5) return "R5";
    if (op == 7) return "R7";
    if (op <= 12) return "R6";
    if (op <= 17) return "R8";
    if (op <= 19) return "R9";
    if (op <= 21) return "R10";
    if (op <= 23) return "R11";
    return "R12";
  endfunction

  function automatic int sx(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // independent arithmetic reference
  task automatic model(input int op, input int a, input int b, input int bi,
                       input logic [7:0] s, output int r, output bit we,
                       output logic [7:0] sn);
    int t, sv, x, y, ci;
    bit c, z, n, v, h, nz, chain;
    c = s[0]; z = s[1]; n = s[2]; v = s[3]; h = s[5];
    sn = s; r = a; we = 0; nz = 0; chain = 0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(c) : 0;
        t = a + b + ci; r = t & 255; c = t > 255;
        h = ((a & 15) + (b & 15) + ci) > 15;
        sv = sx(a) + sx(b) + ci; v = (sv > 127) || (sv < -128);
        we = 1; nz = 1;
      end
      2, 3, 4, 5, 6: begin
        x = (op == 6) ? 0 : a; y = (op == 6) ? a : b;
        ci = (op == 3 || op == 5) ? int'(c) : 0;
        t = x - y - ci; r = t & 255; c = t < 0;
        h = ((x & 15) - (y & 15) - ci) < 0;
        sv = sx(x) - sx(y) - ci; v = (sv > 127) || (sv < -128);
        we = !(op == 4 || op == 5); nz = 1; chain = (op == 3 || op == 5);
      end
      7: begin r = 255 - a; c = 1; v = 0; we = 1; nz = 1; end
      8: begin r = a & b; v = 0; we = 1; nz = 1; end
      9: begin r = a | b; v = 0; we = 1; nz = 1; end
      10: begin r = a ^ b; v = 0; we = 1; nz = 1; end
      11: begin r = (a + 1) % 256; v = (r == 128); we = 1; nz = 1; end
      12: begin r = (a + 255) % 256; v = (r == 127); we = 1; nz = 1; end
      13, 15: begin
        r = ((a * 2) & 255) + ((op == 15) ? int'(c) : 0);
        h = (a / 8) % 2; c = a >= 128; v = (r >= 128) ^ c; we = 1; nz = 1;
      end
      14, 16, 17: begin
        r = a / 2;
        if (op == 16 && c) r += 128;
        if (op == 17 && a >= 128) r += 128;
        c = a % 2; v = (r >= 128) ^ c; we = 1; nz = 1;
      end
      18: begin r = (a % 16) * 16 + a / 16; we = 1; end
      19: begin r = 255; we = 1; end
      20: sn[bi] = 1'b1;
      21: sn[bi] = 1'b0;
      22: sn[6] = a[bi];
      23: begin r = a; if (s[6]) r = r | (1 << bi); else r = r & ~(1 << bi); we = 1; end
      default: we = 0;
    endcase
    if (nz) begin
      n = r >= 128;
      z = chain ? ((r == 0) && z) : (r == 0);
      sn[0] = c; sn[1] = z; sn[2] = n; sn[3] = v; sn[4] = n ^ v; sn[5] = h;
    end
  endtask

  task automatic do_op(input int op, input int a, input int b, input int bi,
                       input bit vld = 1);
    int r; bit we; logic [7:0] sn;
    @(negedge clk);
    op_valid = vld; op_code = 5'(op); opnd_a = 8'(a); opnd_b = 8'(b); bit_idx = 3'(bi);
    model(op, a, b, bi, exp_st, r, we, sn);
    if (!vld) begin we = 0; sn = exp_st; end
    #1;
    chk({req_tag(op), " write enable"}, int'(result_we), int'(we));
    if (we) chk({req_tag(op), " result"}, int'(result), r);
    @(posedge clk); #1;
    chk({req_tag(op), " status"}, int'(status), int'(sn));
    if (vld && op <= 17) chk("R13 S flag", int'(status[4]), int'(sn[4]));
    if (vld && (op == 3 || op == 5)) chk("R4 Z chain", int'(status[1]), int'(sn[1]));
    exp_st = sn;
    op_valid = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", int'(status), 0);
    @(negedge clk); rst_n = 1;
    chk("R1 status after release", int'(status), 0);

    // directed zero chaining across bytes
    do_op(2, 8'h00, 8'h00, 0);        // Z=1, C=0
    do_op(5, 8'h05, 8'h05, 0);        // R4: Z stays 1
    do_op(5, 8'h07, 8'h05, 0);        // R4: Z cleared
    do_op(5, 8'h05, 8'h05, 0);        // R4: equal bytes must not set Z again
    chk("R4 Z stays cleared", int'(status[1]), 0);
    do_op(3, 8'h10, 8'h10, 0);        // R4 with subtract-with-carry
    // R12: undefined opcodes and idle cycles
    for (int u = 24; u < 32; u++) do_op(u, 8'hA5, 8'h3C, u % 8);
    do_op(0, 8'hFF, 8'h01, 0, 0);

    // sweep every opcode, every a, with both incoming C and Z values
    for (int op = 0; op < 24; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 4; k++) begin
          int b;
          b = (k == 0) ? a : (k == 1) ? (255 - a) : ((a * 7 + k * 29 + op * 13) % 256);
          do_op(k[0] ? 20 : 21, 0, 0, 0);
          do_op(k[1] ? 20 : 21, 0, 0, 1);
          do_op(op, a, b, (a + k) % 8);
        end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule